// File: doc/BRIEF.md
# Polled Keyboard and Display I/O Page

This block sits on a 16-bit processor memory bus and splits every access between ordinary RAM and a small page of device registers at the top of the address map. Software drives a keyboard input and a character display with ordinary loads and stores, and waits on each device by testing a ready flag.

The keyboard side takes characters from a valid/data input port and holds one of them until software reads it. The display side hands stored characters to a valid/data output port and watches that port's busy signal to decide when the next character may be stored. Both ready flags are placed in the top bit of their status words, so a sign test in software is enough to check them. Reading the keyboard data word consumes the held key. A store to the display data word starts an output transfer.

Bus reads are combinational: `bus_rdata` is valid in the same cycle as `bus_re`. Side effects take place on the clock edge that ends the access.

Top module: `mmio_io_page`

## Requirements
- R1: Any access with an address of 0xFE00 or above never asserts `ram_re` or `ram_we`. Any access below 0xFE00 forwards its strobe to RAM, and a read there returns `ram_rdata` on `bus_rdata`.
- R2: The keyboard status word at 0xFE00 reads 0x8000 while a key is held and unread, and 0x0000 otherwise. After reset it reads 0x0000.
- R3: The keyboard data word at 0xFE02 returns the held 8-bit character zero-extended to 16 bits. The read clears the keyboard ready flag on the edge that ends the read.
- R4: A key that arrives while the ready flag is set, and no keyboard data read is under way, is dropped, and the held character is unchanged. A key that arrives in the same cycle as a keyboard data read is taken in, and ready stays set.
- R5: Writes to 0xFE00 and 0xFE02 change neither the keyboard ready flag nor the held character.
- R6: The display status word at 0xFE04 reads 0x8000 when a character may be stored, and 0x0000 otherwise. After reset it reads 0x8000.
- R7: A store to 0xFE06 while display ready is set raises `dsp_valid` for exactly one cycle after the store edge, with bits 7:0 of the store on `dsp_char`. The same edge clears display ready.
- R8: After an accepted store, display ready stays clear during the cycle of `dsp_valid`. It then returns to 1 on the first later edge at which `dsp_busy` is low, and stays clear while `dsp_busy` is high.
- R9: A store to 0xFE06 while display ready is clear is dropped: no `dsp_valid` follows, and `dsp_char` keeps the last accepted character.
- R10: Device addresses other than the four register words read 0x0000 and ignore writes. Reading either status word has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released inside on a clock edge |
| bus_addr | input | 16 | Bus byte address |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data, same cycle |
| ram_re | output | 1 | Read strobe passed to RAM |
| ram_we | output | 1 | Write strobe passed to RAM |
| ram_rdata | input | 16 | Read data returned by RAM |
| kb_valid | input | 1 | Keyboard character offered this cycle |
| kb_char | input | 8 | Keyboard character code |
| dsp_valid | output | 1 | Display character presented (one cycle) |
| dsp_char | output | 8 | Display character code |
| dsp_busy | input | 1 | Display still consuming the last character |

## Verification
The bench builds the block with its default parameters: a 16-bit bus and data path, 8-bit characters and the device page based at 0xFE00. With those values the region edge can be probed on both sides (0xFDFF and 0xFE00), along with the last word of the map (0xFFFE) and an odd address inside the page. The 8-bit character width makes the zeroing of the upper data byte visible in both directions. The bench drives the keyboard race cases and the display busy handshake cycle by cycle, so each edge at which a ready flag changes is sampled on its own.

// File: rtl/mmio_page_pkg.sv
package mmio_page_pkg;

  typedef enum logic [2:0] {
    SEL_RAM      = 3'd0,
    SEL_KB_STAT  = 3'd1,
    SEL_KB_DATA  = 3'd2,
    SEL_DSP_STAT = 3'd3,
    SEL_DSP_DATA = 3'd4,
    SEL_UNUSED   = 3'd5
  } page_sel_e;

  // Word offsets of the register words inside the device page
  localparam int unsigned OFS_KB_STAT  = 0;
  localparam int unsigned OFS_KB_DATA  = 2;
  localparam int unsigned OFS_DSP_STAT = 4;
  localparam int unsigned OFS_DSP_DATA = 6;

endpackage

// File: rtl/mmio_page_decode.sv
module mmio_page_decode
  import mmio_page_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] DEV_BASE = 16'hFE00
) (
  input  logic [ADDR_W-1:0] addr,
  output page_sel_e         sel
);

  localparam logic [ADDR_W-1:0] KB_STAT_O  = ADDR_W'(OFS_KB_STAT);
  localparam logic [ADDR_W-1:0] KB_DATA_O  = ADDR_W'(OFS_KB_DATA);
  localparam logic [ADDR_W-1:0] DSP_STAT_O = ADDR_W'(OFS_DSP_STAT);
  localparam logic [ADDR_W-1:0] DSP_DATA_O = ADDR_W'(OFS_DSP_DATA);

  logic [ADDR_W-1:0] page_ofs;

  always_comb begin
    page_ofs = addr - DEV_BASE;
    if (addr < DEV_BASE) begin
      sel = SEL_RAM;
    end else begin
      if (page_ofs == KB_STAT_O)       sel = SEL_KB_STAT;
      else if (page_ofs == KB_DATA_O)  sel = SEL_KB_DATA;
      else if (page_ofs == DSP_STAT_O) sel = SEL_DSP_STAT;
      else if (page_ofs == DSP_DATA_O) sel = SEL_DSP_DATA;
      else                             sel = SEL_UNUSED;
    end
  end

endmodule

// File: rtl/kbd_port_regs.sv
module kbd_port_regs #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  input  logic [CHAR_W-1:0] key_char,
  input  logic              rd_take,
  output logic [DATA_W-1:0] stat_word,
  output logic [DATA_W-1:0] data_word
);

  localparam int unsigned FLAG_BIT = DATA_W - 1;

  logic              ready_q, ready_d;
  logic [CHAR_W-1:0] char_q;
  logic              load_en;

  // next state: a read frees the slot in the same cycle a new key may fill it
  always_comb begin
    load_en = key_valid && (!ready_q || rd_take);
    ready_d = ready_q;
    if (load_en)      ready_d = 1'b1;
    else if (rd_take) ready_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      char_q  <= '0;
    end else begin
      ready_q <= ready_d;
      if (load_en) char_q <= key_char;
    end
  end

  always_comb begin
    stat_word           = '0;
    stat_word[FLAG_BIT] = ready_q;
    data_word           = '0;
    data_word[CHAR_W-1:0] = char_q;
  end

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && !key_valid) |=> !ready_q);

  assert_full_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && key_valid && !rd_take) |=> ($stable(char_q) && ready_q));

  assert_race_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && key_valid) |=> ready_q);

endmodule

// File: rtl/dsp_port_regs.sv
module dsp_port_regs #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store,
  input  logic [DATA_W-1:0] store_word,
  input  logic              out_busy,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_char,
  output logic [DATA_W-1:0] stat_word
);

  localparam int unsigned FLAG_BIT = DATA_W - 1;

  logic              ready_q, ready_d;
  logic              valid_q, valid_d;
  logic [CHAR_W-1:0] char_q;
  logic              accept;
  logic              unused_hi;

  assign unused_hi = ^store_word[DATA_W-1:CHAR_W];

  always_comb begin
    accept  = store && ready_q;
    valid_d = accept;
    ready_d = ready_q;
    if (accept)                                ready_d = 1'b0;
    else if (!ready_q && !valid_q && !out_busy) ready_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b1;
      valid_q <= 1'b0;
      char_q  <= '0;
    end else begin
      ready_q <= ready_d;
      valid_q <= valid_d;
      if (accept) char_q <= store_word[CHAR_W-1:0];
    end
  end

  assign out_valid = valid_q;
  assign out_char  = char_q;

  always_comb begin
    stat_word           = '0;
    stat_word[FLAG_BIT] = ready_q;
  end

  assert_store_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (store && ready_q) |=> (out_valid && !ready_q));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_q && out_busy) |=> !ready_q);

  assert_blocked_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (store && !ready_q) |=> (!out_valid && $stable(char_q)));

endmodule

// File: rtl/mmio_io_page.sv
module mmio_io_page
  import mmio_page_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHAR_W = 8,
  parameter logic [ADDR_W-1:0] DEV_BASE = 16'hFE00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ram_re,
  output logic              ram_we,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic              kb_valid,
  input  logic [CHAR_W-1:0] kb_char,
  output logic              dsp_valid,
  output logic [CHAR_W-1:0] dsp_char,
  input  logic              dsp_busy
);

  // reset: asserted at once, released on a clock edge
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  page_sel_e         sel;
  logic              kb_take;
  logic              dsp_store;
  logic [DATA_W-1:0] kb_stat_w, kb_data_w, dsp_stat_w;

  mmio_page_decode #(
    .ADDR_W   (ADDR_W),
    .DEV_BASE (DEV_BASE)
  ) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  always_comb begin
    ram_re    = bus_re && (sel == SEL_RAM);
    ram_we    = bus_we && (sel == SEL_RAM);
    kb_take   = bus_re && (sel == SEL_KB_DATA);
    dsp_store = bus_we && (sel == SEL_DSP_DATA);
  end

  kbd_port_regs #(
    .DATA_W (DATA_W),
    .CHAR_W (CHAR_W)
  ) u_kbd (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .key_valid (kb_valid),
    .key_char  (kb_char),
    .rd_take   (kb_take),
    .stat_word (kb_stat_w),
    .data_word (kb_data_w)
  );

  dsp_port_regs #(
    .DATA_W (DATA_W),
    .CHAR_W (CHAR_W)
  ) u_dsp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .store      (dsp_store),
    .store_word (bus_wdata),
    .out_busy   (dsp_busy),
    .out_valid  (dsp_valid),
    .out_char   (dsp_char),
    .stat_word  (dsp_stat_w)
  );

  always_comb begin
    unique case (sel)
      SEL_RAM:      bus_rdata = ram_rdata;
      SEL_KB_STAT:  bus_rdata = kb_stat_w;
      SEL_KB_DATA:  bus_rdata = kb_data_w;
      SEL_DSP_STAT: bus_rdata = dsp_stat_w;
      default:      bus_rdata = '0;
    endcase
  end

  assert_dev_isolated_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr >= DEV_BASE) |-> (!ram_re && !ram_we));

  assert_ram_forwarded_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr < DEV_BASE && bus_re) |-> (ram_re && bus_rdata == ram_rdata));

  assert_gap_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_re && bus_addr >= DEV_BASE && (bus_addr - DEV_BASE) > ADDR_W'(OFS_DSP_DATA))
      |-> (bus_rdata == '0));

endmodule

// File: tb/sim_mmio_io_page.sv
module sim_mmio_io_page;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ram_re, ram_we;
  logic [15:0] ram_rdata = 16'hBEEF;
  logic        kb_valid = 1'b0;
  logic [7:0]  kb_char = '0;
  logic        dsp_valid;
  logic [7:0]  dsp_char;
  logic        dsp_busy = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] rd_val;
  logic        rd_ram_re, wr_ram_we;

  always #2 clk = ~clk;

  mmio_io_page u0 (
    .clk (clk), .rst_n (rst_n),
    .bus_addr (bus_addr), .bus_we (bus_we), .bus_re (bus_re),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .ram_re (ram_re), .ram_we (ram_we), .ram_rdata (ram_rdata),
    .kb_valid (kb_valid), .kb_char (kb_char),
    .dsp_valid (dsp_valid), .dsp_char (dsp_char), .dsp_busy (dsp_busy)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_read(input logic [15:0] a);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1;
    rd_val = bus_rdata; rd_ram_re = ram_re;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    #1;
    wr_ram_we = ram_we;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic push_key(input logic [7:0] c);
    @(negedge clk);
    kb_valid = 1'b1; kb_char = c;
    @(negedge clk);
    kb_valid = 1'b0;
  endtask

  task automatic t_reset;
    bus_read(16'hFE00); chk("R2 kb status after reset", rd_val, 16'h0000);
    bus_read(16'hFE04); chk("R6 dsp status after reset", rd_val, 16'h8000);
    chk("R7 no output after reset", {15'd0, dsp_valid}, 16'h0000);
  endtask

  task automatic t_routing;
    bus_read(16'h3000);
    chk("R1 low read data", rd_val, 16'hBEEF);
    chk("R1 low read strobe", {15'd0, rd_ram_re}, 16'h0001);
    bus_read(16'hFDFF);
    chk("R1 edge below page strobe", {15'd0, rd_ram_re}, 16'h0001);
    bus_write(16'h3000, 16'h1111);
    chk("R1 low write strobe", {15'd0, wr_ram_we}, 16'h0001);
    bus_read(16'hFE00);
    chk("R1 page base no ram read", {15'd0, rd_ram_re}, 16'h0000);
    bus_write(16'hFFFE, 16'h2222);
    chk("R1 page top no ram write", {15'd0, wr_ram_we}, 16'h0000);
  endtask

  task automatic t_key_basic;
    push_key(8'h48);
    bus_read(16'hFE00); chk("R2 status with key", rd_val, 16'h8000);
    bus_read(16'hFE02); chk("R3 key data", rd_val, 16'h0048);
    bus_read(16'hFE00); chk("R3 ready cleared by read", rd_val, 16'h0000);
  endtask

  task automatic t_key_drop;
    push_key(8'h41);
    push_key(8'h42);
    bus_read(16'hFE02); chk("R4 second key dropped", rd_val, 16'h0041);
    bus_read(16'hFE00); chk("R4 status after drop", rd_val, 16'h0000);
  endtask

  task automatic t_key_race;
    push_key(8'h43);
    @(negedge clk);
    bus_addr = 16'hFE02; bus_re = 1'b1; kb_valid = 1'b1; kb_char = 8'h44;
    #1;
    rd_val = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0; kb_valid = 1'b0;
    chk("R4 race read returns old", rd_val, 16'h0043);
    bus_read(16'hFE00); chk("R4 race keeps ready", rd_val, 16'h8000);
    bus_read(16'hFE02); chk("R4 race new key held", rd_val, 16'h0044);
  endtask

  task automatic t_key_writes;
    push_key(8'h45);
    bus_write(16'hFE02, 16'h1234);
    bus_write(16'hFE00, 16'h0000);
    bus_read(16'hFE00); chk("R5 ready survives writes", rd_val, 16'h8000);
    bus_read(16'hFE00); chk("R10 status read no side effect", rd_val, 16'h8000);
    bus_read(16'hFE02); chk("R5 char survives writes", rd_val, 16'h0045);
  endtask

  task automatic t_display_free;
    bus_write(16'hFE06, 16'hA55A);
    chk("R7 valid after store", {15'd0, dsp_valid}, 16'h0001);
    chk("R7 char low byte", {8'd0, dsp_char}, 16'h005A);
    bus_read(16'hFE04); chk("R8 ready clear in valid cycle+1", rd_val, 16'h0000);
    chk("R7 valid is one cycle", {15'd0, dsp_valid}, 16'h0000);
    bus_read(16'hFE04); chk("R8 ready back with busy low", rd_val, 16'h8000);
  endtask

  task automatic t_display_busy;
    bus_write(16'hFE06, 16'h0061);
    dsp_busy = 1'b1;
    chk("R7 valid with char a", {8'd0, dsp_char}, 16'h0061);
    repeat (4) @(negedge clk);
    bus_read(16'hFE04); chk("R8 ready held while busy", rd_val, 16'h0000);
    bus_write(16'hFE06, 16'h0062);
    chk("R9 blocked store no valid", {15'd0, dsp_valid}, 16'h0000);
    dsp_busy = 1'b0;
    bus_read(16'hFE04); chk("R8 ready after busy drop", rd_val, 16'h8000);
    chk("R9 char kept after blocked store", {8'd0, dsp_char}, 16'h0061);
  endtask

  task automatic t_unused;
    bus_read(16'hFE08); chk("R10 unused word reads zero", rd_val, 16'h0000);
    bus_read(16'hFFFE); chk("R10 last word reads zero", rd_val, 16'h0000);
    bus_read(16'hFE01); chk("R10 odd address reads zero", rd_val, 16'h0000);
    push_key(8'h4A);
    bus_write(16'hFE08, 16'hFFFF);
    bus_write(16'hFE05, 16'hFFFF);
    bus_read(16'hFE00); chk("R10 unused write keeps kb", rd_val, 16'h8000);
    bus_read(16'hFE04); chk("R10 unused write keeps dsp", rd_val, 16'h8000);
    chk("R10 unused write no output", {15'd0, dsp_valid}, 16'h0000);
    bus_read(16'hFE02); chk("R10 kb char intact", rd_val, 16'h004A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_routing();
    t_key_basic();
    t_key_drop();
    t_key_race();
    t_key_writes();
    t_display_free();
    t_display_busy();
    t_unused();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0000, 16'h0001);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule